// File: doc/BRIEF.md
# APB5 Completer-Side Interface Parity Guard

This block sits between an APB5 requester and a completer's register logic. It watches every incoming signal group (address, control, select, enable and write data) and compares each group against the odd-parity check bits the requester drives alongside it. When a group and its check bits together hold an even number of ones while checking is enabled, the block reports a fault for that group. It does not correct anything; it only reports.

The report takes two forms per group. A registered pulse marks each offending cycle. A sticky bit stays set until reset or until the owner pulses a clear input. On the return path the block forms the odd-parity check bits for the read data, one per byte lane, and for the ready and error responses. These check bits are combinational, so they line up with the response values in the same cycle.

Error vector bit order, shared by `err_pulse` and `err_sticky`: bit 0 address, bit 1 control, bit 2 select, bit 3 enable, bit 4 write data.

Top module: `apb_par_guard`

## Requirements
- R1: The address is split into 8-bit slices, and `addr_chk[i]` guards slice i. With `chk_en` and `bus_sel` high, a slice whose bits plus its check bit hold an even count of ones sets error bit 0.
- R2: The control group is the concatenation {`bus_wr`, `bus_prot`, `bus_strb`, `bus_nse`}, guarded by the single bit `ctrl_chk`. An even total count of ones across the group and its check bit sets error bit 1, under the same qualification as R1.
- R3: `sel_chk` guards `bus_sel` alone and `en_chk` guards `bus_en` alone. A fault on either sets error bit 2 or error bit 3 in any cycle where `chk_en` is high, whatever the state of `bus_sel`.
- R4: Write data has one check bit per byte lane, with `wdata_chk[i]` guarding bits 8i+7..8i. An even count in any lane sets error bit 4, under the same qualification as R1.
- R5: Address, control and write-data faults are ignored in cycles where `bus_sel` is low.
- R6: No error bit is set in response to a cycle in which `chk_en` is low.
- R7: `err_pulse` is registered. It is high in the cycle after each offending cycle and low after a clean cycle.
- R8: A bit of `err_sticky` sets together with its pulse. It stays set until reset, or until a cycle in which `clr` is high and the group shows no new fault. A new fault takes priority over a clear in the same cycle.
- R9: `rdata_par[i]` makes byte lane i of `rsp_rdata` plus itself odd, in the same cycle as the data.
- R10: `ready_par` makes {`rsp_ready`, `ready_par`} odd, and `err_par` makes {`rsp_err`, `err_par`} odd, both combinationally.
- R11: A synchronous active-high reset clears `err_pulse` and `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Enables fault reporting for the current cycle |
| clr | input | 1 | Clears sticky error bits |
| bus_sel | input | 1 | Completer select |
| bus_en | input | 1 | Access-phase enable |
| bus_wr | input | 1 | Write direction |
| bus_prot | input | PROT_W | Protection attributes |
| bus_strb | input | DATA_W/8 | Write byte strobes |
| bus_nse | input | 1 | Security-extension attribute |
| bus_addr | input | ADDR_W | Address |
| bus_wdata | input | DATA_W | Write data |
| addr_chk | input | ADDR_W/8 | Address check bits, one per slice |
| ctrl_chk | input | 1 | Control group check bit |
| sel_chk | input | 1 | Select check bit |
| en_chk | input | 1 | Enable check bit |
| wdata_chk | input | DATA_W/8 | Write data check bits, one per lane |
| rsp_rdata | input | DATA_W | Outgoing read data from the completer |
| rsp_ready | input | 1 | Outgoing ready from the completer |
| rsp_err | input | 1 | Outgoing error response from the completer |
| rdata_par | output | DATA_W/8 | Read data check bits |
| ready_par | output | 1 | Ready check bit |
| err_par | output | 1 | Error-response check bit |
| err_pulse | output | 5 | Per-group fault pulse |
| err_sticky | output | 5 | Per-group sticky fault |

## Verification
The bench builds the block with a 16-bit address and 64-bit data. The two address slices let a fault in the upper slice be told apart from one in the lower slice. The eight data lanes show that the top lane of both the write and read check vectors is mapped, not only lane 0. The control group then spans 13 bits, with eight strobes. A single flipped strobe therefore shows that the strobes are inside that group's parity.

// File: rtl/apb_par_pkg.sv
package apb_par_pkg;
  localparam int GRP_N  = 5;
  localparam int G_ADDR = 0;
  localparam int G_CTRL = 1;
  localparam int G_SEL  = 2;
  localparam int G_EN   = 3;
  localparam int G_WDAT = 4;
  localparam int SLICE_W = 8;
endpackage

// File: rtl/par_slicer.sv
module par_slicer #(
  parameter int W     = 32,
  parameter int SLICE = 8,
  localparam int N    = (W + SLICE - 1) / SLICE
) (
  input  logic [W-1:0] din,
  output logic [N-1:0] par
);
  for (genvar i = 0; i < N; i++) begin : g_slice
    localparam int LO = i * SLICE;
    localparam int HI = ((i + 1) * SLICE > W) ? W - 1 : (i + 1) * SLICE - 1;
    // fill bit that makes the slice plus itself odd
    assign par[i] = ~^din[HI:LO];
  end
endmodule

// File: rtl/par_compare.sv
module par_compare #(
  parameter int N = 4
) (
  input  logic [N-1:0] want,
  input  logic [N-1:0] got,
  output logic         mismatch
);
  assign mismatch = |(want ^ got);
endmodule

// File: rtl/err_track.sv
module err_track #(
  parameter int G = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [G-1:0] hit,
  output logic [G-1:0] pulse,
  output logic [G-1:0] sticky
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= '0;
      sticky <= '0;
    end else begin
      pulse  <= hit;
      sticky <= (sticky & ~{G{clr}}) | hit;
    end
  end
endmodule

// File: rtl/apb_par_guard.sv
module apb_par_guard
  import apb_par_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PROT_W = 3,
  localparam int STRB_W = DATA_W / SLICE_W,
  localparam int ASL_N  = ADDR_W / SLICE_W,
  localparam int CTRL_W = 1 + PROT_W + STRB_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_en,
  input  logic              clr,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [PROT_W-1:0] bus_prot,
  input  logic [STRB_W-1:0] bus_strb,
  input  logic              bus_nse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ASL_N-1:0]  addr_chk,
  input  logic              ctrl_chk,
  input  logic              sel_chk,
  input  logic              en_chk,
  input  logic [STRB_W-1:0] wdata_chk,
  input  logic [DATA_W-1:0] rsp_rdata,
  input  logic              rsp_ready,
  input  logic              rsp_err,
  output logic [STRB_W-1:0] rdata_par,
  output logic              ready_par,
  output logic              err_par,
  output logic [GRP_N-1:0]  err_pulse,
  output logic [GRP_N-1:0]  err_sticky
);
  logic [CTRL_W-1:0] ctrl_vec;
  logic [ASL_N-1:0]  addr_want;
  logic [STRB_W-1:0] wdat_want;
  logic              ctrl_want, sel_want, en_want;
  logic [GRP_N-1:0]  mis, hit;

  assign ctrl_vec = {bus_wr, bus_prot, bus_strb, bus_nse};

  par_slicer #(.W(ADDR_W), .SLICE(SLICE_W)) u_addr_p (.din(bus_addr),  .par(addr_want));
  par_slicer #(.W(CTRL_W), .SLICE(CTRL_W))  u_ctrl_p (.din(ctrl_vec),  .par(ctrl_want));
  par_slicer #(.W(1),      .SLICE(1))       u_sel_p  (.din(bus_sel),   .par(sel_want));
  par_slicer #(.W(1),      .SLICE(1))       u_en_p   (.din(bus_en),    .par(en_want));
  par_slicer #(.W(DATA_W), .SLICE(SLICE_W)) u_wdat_p (.din(bus_wdata), .par(wdat_want));

  par_compare #(.N(ASL_N))  u_addr_c (.want(addr_want), .got(addr_chk),  .mismatch(mis[G_ADDR]));
  par_compare #(.N(1))      u_ctrl_c (.want(ctrl_want), .got(ctrl_chk),  .mismatch(mis[G_CTRL]));
  par_compare #(.N(1))      u_sel_c  (.want(sel_want),  .got(sel_chk),   .mismatch(mis[G_SEL]));
  par_compare #(.N(1))      u_en_c   (.want(en_want),   .got(en_chk),    .mismatch(mis[G_EN]));
  par_compare #(.N(STRB_W)) u_wdat_c (.want(wdat_want), .got(wdata_chk), .mismatch(mis[G_WDAT]));

  // payload groups qualified by select; select and enable always checked
  always_comb begin
    hit         = '0;
    hit[G_ADDR] = chk_en & bus_sel & mis[G_ADDR];
    hit[G_CTRL] = chk_en & bus_sel & mis[G_CTRL];
    hit[G_WDAT] = chk_en & bus_sel & mis[G_WDAT];
    hit[G_SEL]  = chk_en & mis[G_SEL];
    hit[G_EN]   = chk_en & mis[G_EN];
  end

  err_track #(.G(GRP_N)) u_track (
    .clk(clk), .rst(rst), .clr(clr), .hit(hit),
    .pulse(err_pulse), .sticky(err_sticky)
  );

  // return path check bits
  par_slicer #(.W(DATA_W), .SLICE(SLICE_W)) u_rdat_p (.din(rsp_rdata), .par(rdata_par));
  par_slicer #(.W(1), .SLICE(1)) u_rdy_p (.din(rsp_ready), .par(ready_par));
  par_slicer #(.W(1), .SLICE(1)) u_err_p (.din(rsp_err),   .par(err_par));
endmodule

// File: rtl/apb_par_guard_chk.sv
module apb_par_guard_chk #(
  parameter int DATA_W = 32,
  localparam int LN = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              chk_en,
  input logic              clr,
  input logic              bus_sel,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [LN-1:0]     rdata_par,
  input logic              ready_par,
  input logic              err_par,
  input logic [4:0]        err_pulse,
  input logic [4:0]        err_sticky
);
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> err_pulse == 5'b0);

  a_r5_payload_needs_sel: assert property (@(posedge clk) disable iff (rst)
    !bus_sel |=> !err_pulse[0] && !err_pulse[1] && !err_pulse[4]);

  a_r8_pulse_sets_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_pulse & ~err_sticky) == 5'b0);

  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (err_sticky & $past(err_sticky)) == $past(err_sticky));

  a_r10_ready_odd: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready ^ ready_par) == 1'b1);

  a_r10_err_odd: assert property (@(posedge clk) disable iff (rst)
    (rsp_err ^ err_par) == 1'b1);

  for (genvar i = 0; i < LN; i++) begin : g_lane
    a_r9_rdata_lane_odd: assert property (@(posedge clk) disable iff (rst)
      ^{rsp_rdata[8*i +: 8], rdata_par[i]} == 1'b1);
  end
endmodule

bind apb_par_guard apb_par_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .chk_en(chk_en), .clr(clr), .bus_sel(bus_sel),
  .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
  .rdata_par(rdata_par), .ready_par(ready_par), .err_par(err_par),
  .err_pulse(err_pulse), .err_sticky(err_sticky)
);

// File: tb/tb_apb_par_guard.sv
`timescale 1ns/1ps
module tb_apb_par_guard;
  localparam int AW = 16, DW = 64, PW = 3;
  localparam int SW = DW / 8, NA = AW / 8;

  logic clk = 0, rst = 1, chk_en = 0, clr = 0;
  logic sel = 0, en = 0, wr = 0, nse = 0;
  logic [PW-1:0] prot = '0;
  logic [SW-1:0] strb = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata = '0;
  logic ready = 0, serr = 0;
  logic [NA-1:0] addr_chk = '0;
  logic ctrl_chk = 0, sel_chk = 0, en_chk = 0;
  logic [SW-1:0] wdata_chk = '0;
  logic [SW-1:0] rdata_par;
  logic ready_par, err_par;
  logic [4:0] err_pulse, err_sticky;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  apb_par_guard #(.ADDR_W(AW), .DATA_W(DW), .PROT_W(PW)) dut (
    .clk(clk), .rst(rst), .chk_en(chk_en), .clr(clr),
    .bus_sel(sel), .bus_en(en), .bus_wr(wr), .bus_prot(prot), .bus_strb(strb),
    .bus_nse(nse), .bus_addr(addr), .bus_wdata(wdata),
    .addr_chk(addr_chk), .ctrl_chk(ctrl_chk), .sel_chk(sel_chk), .en_chk(en_chk),
    .wdata_chk(wdata_chk), .rsp_rdata(rdata), .rsp_ready(ready), .rsp_err(serr),
    .rdata_par(rdata_par), .ready_par(ready_par), .err_par(err_par),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  function automatic logic obit(input logic [63:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  task automatic fix_parity();
    for (int i = 0; i < NA; i++) addr_chk[i] = obit(64'(addr[8*i +: 8]));
    ctrl_chk = obit(64'({wr, prot, strb, nse}));
    sel_chk  = obit(64'(sel));
    en_chk   = obit(64'(en));
    for (int i = 0; i < SW; i++) wdata_chk[i] = obit(64'(wdata[8*i +: 8]));
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_flags(input string req, input logic [4:0] p, input logic [4:0] s);
    check(err_pulse == p, {req, " pulse"}, 64'(err_pulse), 64'(p));
    check(err_sticky == s, {req, " sticky"}, 64'(err_sticky), 64'(s));
  endtask

  task automatic clear_all();
    fix_parity(); clr = 1; step(); clr = 0; step();
  endtask

  task automatic t_reset();
    sel = 1; addr = '1; fix_parity(); addr_chk = ~addr_chk; chk_en = 1; rst = 1;
    step(); step();
    expect_flags("R11 reset", 5'b0, 5'b0);
    rst = 0; fix_parity(); step(); step();
  endtask

  task automatic t_clean();
    sel = 1; en = 0; wr = 1; prot = 3'b101; strb = 8'hA5; nse = 1;
    addr = 16'h3C71; wdata = 64'h0123_4567_89AB_CDEF; fix_parity(); step();
    en = 1; fix_parity(); step();
    expect_flags("R1 clean transfer", 5'b0, 5'b0);
  endtask

  task automatic t_addr();
    fix_parity(); addr_chk[1] = ~addr_chk[1]; step();
    expect_flags("R1 upper address slice", 5'b00001, 5'b00001);
    fix_parity(); step();
    check(err_pulse == 0, "R7 pulse drops after clean cycle", 64'(err_pulse), 0);
    check(err_sticky == 5'b00001, "R8 sticky holds", 64'(err_sticky), 1);
    clear_all();
    addr = 16'h0080; fix_parity(); addr_chk[0] = ~addr_chk[0]; step();
    expect_flags("R1 lower address slice", 5'b00001, 5'b00001);
    clear_all();
  endtask

  task automatic t_ctrl();
    fix_parity(); strb[7] = ~strb[7]; step();
    expect_flags("R2 strobe in control group", 5'b00010, 5'b00010);
    strb[7] = ~strb[7]; fix_parity(); nse = ~nse; step();
    check(err_pulse == 5'b00010, "R2 nse in control group", 64'(err_pulse), 2);
    clear_all();
  endtask

  task automatic t_wdata();
    fix_parity(); wdata_chk[7] = ~wdata_chk[7]; step();
    expect_flags("R4 top write lane", 5'b10000, 5'b10000);
    clear_all();
    fix_parity(); wdata[3] = ~wdata[3]; step();
    check(err_pulse == 5'b10000, "R4 lane 0 data flip", 64'(err_pulse), 16);
    clear_all();
  endtask

  task automatic t_idle_sel_en();
    sel = 0; en = 0; fix_parity(); sel_chk = ~sel_chk; step();
    expect_flags("R3 select fault while idle", 5'b00100, 5'b00100);
    fix_parity(); en_chk = ~en_chk; step();
    check(err_pulse == 5'b01000, "R3 enable fault while idle", 64'(err_pulse), 8);
    clear_all();
  endtask

  task automatic t_nosel_gate();
    sel = 0; fix_parity(); addr_chk = ~addr_chk; ctrl_chk = ~ctrl_chk; wdata_chk = ~wdata_chk;
    step();
    expect_flags("R5 payload ignored without select", 5'b0, 5'b0);
    sel = 1; fix_parity(); step();
  endtask

  task automatic t_disabled();
    chk_en = 0; fix_parity();
    addr_chk = ~addr_chk; ctrl_chk = ~ctrl_chk; sel_chk = ~sel_chk; en_chk = ~en_chk; wdata_chk = ~wdata_chk;
    step();
    expect_flags("R6 checking disabled", 5'b0, 5'b0);
    chk_en = 1; fix_parity(); step();
  endtask

  task automatic t_clear_priority();
    fix_parity(); addr_chk[0] = ~addr_chk[0]; step();
    clr = 1; step();
    check(err_sticky[0] == 1'b1, "R8 set wins over clear", 64'(err_sticky), 1);
    fix_parity(); step();
    clr = 0;
    check(err_sticky == 0, "R8 clear drops sticky", 64'(err_sticky), 0);
    step();
  endtask

  task automatic t_return();
    logic [SW-1:0] exp;
    rdata = 64'h8000_0000_0000_0001; ready = 1; serr = 0; #1;
    for (int i = 0; i < SW; i++) exp[i] = obit(64'(rdata[8*i +: 8]));
    check(rdata_par == exp, "R9 read lanes pattern a", 64'(rdata_par), 64'(exp));
    check(ready_par == 1'b0 && err_par == 1'b1, "R10 ready1 err0", {62'b0, ready_par, err_par}, 64'b01);
    rdata = 64'hFF00_1234_0F0F_7E81; ready = 0; serr = 1; #1;
    for (int i = 0; i < SW; i++) exp[i] = obit(64'(rdata[8*i +: 8]));
    check(rdata_par == exp, "R9 read lanes pattern b", 64'(rdata_par), 64'(exp));
    check(ready_par == 1'b1 && err_par == 1'b0, "R10 ready0 err1", {62'b0, ready_par, err_par}, 64'b10);
    step();
  endtask

  initial begin
    fix_parity();
    step();
    t_reset();
    t_clean();
    t_addr();
    t_ctrl();
    t_wdata();
    t_idle_sel_en();
    t_nosel_gate();
    t_disabled();
    t_clear_priority();
    t_return();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule